// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads a four-level tree of 64-bit table entries through a narrow memory read port, one entry per request, starting from a root table base. Each request carries three access attributes: write, user mode and instruction fetch. The block returns one of two results. On success it gives the physical address, the page size and the merged rights (writable, user, no-execute). On failure it gives a fault with a five-bit error code. Walks can end early on 1 GiB and 2 MiB mappings. An address that is not in canonical form is rejected before any memory is read.

The block is controlled by a four-state machine. WS_IDLE accepts a request. If the address is canonical, it goes to WS_FETCH. If not, it goes straight to WS_DONE. WS_FETCH presents a read and moves to WS_WAIT once the memory accepts the read. WS_WAIT takes the returned entry. If the entry is not present, sets a reserved bit, or is a leaf, the machine goes to WS_DONE. Otherwise it steps down one level and goes back to WS_FETCH. WS_DONE holds the result until it is accepted and then returns to WS_IDLE. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: An address whose bits 63:47 are not all equal faults at once, with `rsp_canon_fault`=1 and error bit 0 clear, and no memory read is made. Addresses in either canonical half are walked.
- R2: A 4 KiB walk makes exactly four reads. Each read is at the table base plus 8 times the index, where the indices are VA[47:39], VA[38:30], VA[29:21] and VA[20:12]. The next base comes from entry bits 51:12. The result is entry[51:12] followed by VA[11:0].
- R3: An entry at the second-highest level with bit 7 set maps a 1 GiB page after two reads. The result is entry[51:30] followed by VA[29:0].
- R4: An entry at the third level with bit 7 set maps a 2 MiB page after three reads. The result is entry[51:21] followed by VA[20:0]. Entry bit 12 is not part of the frame address.
- R5: An entry with bit 0 (present) clear, at any level, ends the walk after that read. It reports a fault with error bit 0 clear.
- R6: The writable right (entry bit 1) and the user right (entry bit 2) are each the AND across all entries walked. A write without the writable right, or a user access without the user right, faults with error bit 0 set.
- R7: An instruction fetch faults with error bit 0 set when any walked entry has bit 63 set, but only if `nx_enable` was 1 when the request was accepted. The merged no-execute flag (the OR of bit 63 across the walk) is reported on success.
- R8: On any fault, error bit 1 equals the write attribute, bit 2 the user attribute and bit 4 the fetch attribute. On success the error code is zero.
- R9: A present entry has a reserved-bit violation in two cases: bit 7 is set in a top-level entry, or a huge entry has nonzero frame bits below its page alignment (bits 29:13 for 1 GiB, 20:13 for 2 MiB). Such an entry ends the walk with error bits 0 and 3 set.
- R10: `req_ready` is high only when no walk is active. A memory read that is not yet accepted keeps its address. A result that is not yet accepted keeps `rsp_valid` and its values.
- R11: After reset the block is idle: `req_ready`=1, `mem_req_valid`=0, `rsp_valid`=0.
- R12: On success, `rsp_page_size` is 0 for 4 KiB, 1 for 2 MiB and 2 for 1 GiB. `rsp_writable` and `rsp_user` give the merged rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nx_enable | input | 1 | Enables no-execute enforcement; sampled when a request is accepted |
| root_base | input | PA_W | Physical base of the top-level table (low 12 bits ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_ready | output | 1 | Walker waiting for entry data |
| mem_rsp_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result accepted |
| rsp_fault | output | 1 | Translation failed |
| rsp_canon_fault | output | 1 | Failure due to a non-canonical address |
| rsp_err | output | 5 | Fault error code |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_page_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| rsp_writable | output | 1 | Merged writable right |
| rsp_user | output | 1 | Merged user right |
| rsp_nx | output | 1 | Merged no-execute flag |

## Verification
The walker is tried against one prepared table tree with several kinds of address.

- **Full-depth walks** show that indexing and offset splicing are correct.
- **Walks ending on 1 GiB and 2 MiB entries** show the early stop, through both the read count and the wider offset. One such entry has only bit 12 set in its low frame bits, which separates alignment checking from the address field.
- **Paths whose rights differ between levels** show that the rights are ANDed across levels rather than taken from the leaf.
- **The same no-execute page fetched with enforcement on and then off** shows that the enable input is honoured.
- **Missing, misaligned and top-level huge entries** show the stop level through the read count, and the error code bits.
- **Addresses just inside and just outside both canonical halves** show that the range check sits exactly at the boundary.
- **A run with memory stalls and a held result** shows that the handshakes keep their values while waiting.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int LEVELS    = 4;
    localparam int LVL_W     = $clog2(LEVELS);
    localparam int IDX_W     = 9;
    localparam int OFF_W     = 12;
    localparam int VA_BITS   = OFF_W + LEVELS * IDX_W;
    localparam int ENTRY_W   = 64;
    localparam int MIB_SHIFT = OFF_W + IDX_W;
    localparam int GIB_SHIFT = OFF_W + 2 * IDX_W;
    localparam int EC_W      = 5;

    // entry bit positions
    localparam int PTE_P  = 0;
    localparam int PTE_W  = 1;
    localparam int PTE_U  = 2;
    localparam int PTE_PS = 7;
    localparam int PTE_NX = 63;

    // error code bit positions
    localparam int EC_PROT  = 0;
    localparam int EC_WRITE = 1;
    localparam int EC_USER  = 2;
    localparam int EC_RSVD  = 3;
    localparam int EC_FETCH = 4;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_FETCH,
        WS_WAIT,
        WS_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } page_size_e;

    typedef struct packed {
        logic write;
        logic user;
        logic fetch;
    } access_t;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split
    import pt_walker_pkg::*;
(
    input  logic [63:0]                  va,
    output logic                         canonical,
    output logic [LEVELS-1:0][IDX_W-1:0] idx
);

    localparam int SIGN_BITS = 64 - VA_BITS + 1;

    assign canonical = (&va[63:VA_BITS-1]) | ~(|va[63:VA_BITS-1]);

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = va[OFF_W + g*IDX_W +: IDX_W];
    end

    logic unused_sign;
    assign unused_sign = ^{va[OFF_W-1:0], SIGN_BITS[0]};

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
    import pt_walker_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   level,
    input  logic [GIB_SHIFT-1:0] va_low,
    output logic               present,
    output logic               rsvd,
    output logic               leaf,
    output logic               wr,
    output logic               usr,
    output logic               nx,
    output logic [PA_W-1:0]    next_base,
    output logic [PA_W-1:0]    leaf_pa,
    output page_size_e         size
);

    logic ps, huge_lvl, misalign, top_ps, high_rsvd;

    assign present = entry[PTE_P];
    assign wr      = entry[PTE_W];
    assign usr     = entry[PTE_U];
    assign nx      = entry[PTE_NX];
    assign ps      = entry[PTE_PS];

    assign huge_lvl = (level == LVL_W'(1)) | (level == LVL_W'(2));
    assign top_ps   = ps & (level == LVL_W'(LEVELS-1));

    always_comb begin
        unique case (level)
            LVL_W'(2): misalign = |entry[GIB_SHIFT-1:OFF_W+1];
            LVL_W'(1): misalign = |entry[MIB_SHIFT-1:OFF_W+1];
            default:   misalign = 1'b0;
        endcase
    end

    if (PA_W < 52) begin : g_narrow
        assign high_rsvd = |entry[51:PA_W];
    end else begin : g_full
        assign high_rsvd = 1'b0;
    end

    assign rsvd = present & (top_ps | (ps & huge_lvl & misalign) | high_rsvd);
    assign leaf = present & ~rsvd & ((level == '0) | (ps & huge_lvl));

    assign next_base = {entry[PA_W-1:OFF_W], {OFF_W{1'b0}}};

    always_comb begin
        unique case (level)
            LVL_W'(2): begin
                leaf_pa = {entry[PA_W-1:GIB_SHIFT], va_low[GIB_SHIFT-1:0]};
                size    = PG_1G;
            end
            LVL_W'(1): begin
                leaf_pa = {entry[PA_W-1:MIB_SHIFT], va_low[MIB_SHIFT-1:0]};
                size    = PG_2M;
            end
            default: begin
                leaf_pa = {entry[PA_W-1:OFF_W], va_low[OFF_W-1:0]};
                size    = PG_4K;
            end
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{entry[62:52], entry[11:8], entry[6:3]};

endmodule

// File: rtl/pt_fault_code.sv
module pt_fault_code
    import pt_walker_pkg::*;
(
    input  access_t         acc,
    input  logic            prot,
    input  logic            rsvd,
    output logic [EC_W-1:0] code
);

    always_comb begin
        code           = '0;
        code[EC_PROT]  = prot;
        code[EC_WRITE] = acc.write;
        code[EC_USER]  = acc.user;
        code[EC_RSVD]  = rsvd;
        code[EC_FETCH] = acc.fetch;
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nx_enable,
    input  logic [PA_W-1:0] root_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [63:0]     req_va,
    input  logic            req_write,
    input  logic            req_user,
    input  logic            req_fetch,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    output logic            mem_rsp_ready,
    input  logic [63:0]     mem_rsp_data,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic            rsp_fault,
    output logic            rsp_canon_fault,
    output logic [EC_W-1:0] rsp_err,
    output logic [PA_W-1:0] rsp_pa,
    output logic [1:0]      rsp_page_size,
    output logic            rsp_writable,
    output logic            rsp_user,
    output logic            rsp_nx
);

    walk_state_e state_q, state_d;

    logic [LVL_W-1:0] level_q;
    logic [PA_W-1:0]  base_q;
    logic [63:0]      va_q;
    access_t          acc_q;
    logic             nxe_q;
    logic             w_q, u_q, nx_q;
    logic             fault_q, canon_q;
    logic [EC_W-1:0]  err_q;
    logic [PA_W-1:0]  pa_q;
    page_size_e       size_q;

    // address split (request address while idle, held address while walking)
    logic                         idle;
    logic [63:0]                  split_va;
    logic                         va_canon;
    logic [LEVELS-1:0][IDX_W-1:0] va_idx;

    assign idle     = (state_q == WS_IDLE);
    assign split_va = idle ? req_va : va_q;

    pt_va_split u_split (
        .va        (split_va),
        .canonical (va_canon),
        .idx       (va_idx)
    );

    // entry decode
    logic            ent_p, ent_rsvd, ent_leaf, ent_w, ent_u, ent_nx;
    logic [PA_W-1:0] ent_next, ent_pa;
    page_size_e      ent_size;

    pt_entry_eval #(.PA_W(PA_W)) u_eval (
        .entry     (mem_rsp_data),
        .level     (level_q),
        .va_low    (va_q[GIB_SHIFT-1:0]),
        .present   (ent_p),
        .rsvd      (ent_rsvd),
        .leaf      (ent_leaf),
        .wr        (ent_w),
        .usr       (ent_u),
        .nx        (ent_nx),
        .next_base (ent_next),
        .leaf_pa   (ent_pa),
        .size      (ent_size)
    );

    // merged rights and permission check
    logic m_w, m_u, m_nx, viol, walk_end, walk_fault;

    assign m_w  = w_q & ent_w;
    assign m_u  = u_q & ent_u;
    assign m_nx = nx_q | ent_nx;

    assign viol = (acc_q.write & ~m_w) | (acc_q.user & ~m_u) | (acc_q.fetch & nxe_q & m_nx);

    assign walk_end   = ~ent_p | ent_rsvd | ent_leaf;
    assign walk_fault = ~ent_p | ent_rsvd | (ent_leaf & viol);

    // fault code
    access_t         code_acc;
    logic            in_wait;
    logic [EC_W-1:0] fc_code;

    assign in_wait  = (state_q == WS_WAIT);
    assign code_acc = idle ? access_t'{write: req_write, user: req_user, fetch: req_fetch} : acc_q;

    pt_fault_code u_code (
        .acc  (code_acc),
        .prot (in_wait & ent_p & (ent_rsvd | (ent_leaf & viol))),
        .rsvd (in_wait & ent_rsvd),
        .code (fc_code)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (req_valid)     state_d = va_canon ? WS_FETCH : WS_DONE;
            WS_FETCH: if (mem_req_ready) state_d = WS_WAIT;
            WS_WAIT:  if (mem_rsp_valid) state_d = walk_end ? WS_DONE : WS_FETCH;
            WS_DONE:  if (rsp_ready)     state_d = WS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            base_q  <= '0;
            va_q    <= '0;
            acc_q   <= '0;
            nxe_q   <= 1'b0;
            w_q     <= 1'b0;
            u_q     <= 1'b0;
            nx_q    <= 1'b0;
            fault_q <= 1'b0;
            canon_q <= 1'b0;
            err_q   <= '0;
            pa_q    <= '0;
            size_q  <= PG_4K;
        end else begin
            unique case (state_q)
                WS_IDLE: if (req_valid) begin
                    va_q    <= req_va;
                    acc_q   <= code_acc;
                    nxe_q   <= nx_enable;
                    level_q <= LVL_W'(LEVELS-1);
                    base_q  <= {root_base[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                    w_q     <= 1'b1;
                    u_q     <= 1'b1;
                    nx_q    <= 1'b0;
                    canon_q <= ~va_canon;
                    fault_q <= ~va_canon;
                    err_q   <= va_canon ? '0 : fc_code;
                    pa_q    <= '0;
                    size_q  <= PG_4K;
                end
                WS_WAIT: if (mem_rsp_valid) begin
                    w_q  <= m_w;
                    u_q  <= m_u;
                    nx_q <= m_nx;
                    if (walk_end) begin
                        fault_q <= walk_fault;
                        err_q   <= walk_fault ? fc_code : '0;
                        pa_q    <= ent_pa;
                        size_q  <= ent_size;
                    end else begin
                        base_q  <= ent_next;
                        level_q <= level_q - LVL_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready       = (state_q == WS_IDLE);
        mem_req_valid   = (state_q == WS_FETCH);
        mem_rsp_ready   = (state_q == WS_WAIT);
        rsp_valid       = (state_q == WS_DONE);
        mem_req_addr    = {base_q[PA_W-1:OFF_W], va_idx[level_q], 3'b000};
        rsp_fault       = fault_q;
        rsp_canon_fault = canon_q;
        rsp_err         = err_q;
        rsp_pa          = pa_q;
        rsp_page_size   = size_q;
        rsp_writable    = w_q;
        rsp_user        = u_q;
        rsp_nx          = nx_q;
    end

    logic unused_root;
    assign unused_root = ^root_base[OFF_W-1:0];

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walker_pkg::*;
#(
    parameter int PA_W = 52
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic            rsp_fault,
    input logic            rsp_canon_fault,
    input logic [EC_W-1:0] rsp_err,
    input logic [PA_W-1:0] rsp_pa
);

    logic [3:0] walk_reads;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             walk_reads <= '0;
        else if (req_valid && req_ready)        walk_reads <= '0;
        else if (mem_req_valid && mem_req_ready) walk_reads <= walk_reads + 4'd1;
    end

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_err) && $stable(rsp_fault));

    // R10
    single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !mem_rsp_ready && !rsp_valid);

    // R2
    read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_reads <= 4'd4);

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

    // R1
    canon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_canon_fault |-> rsp_fault && !rsp_err[EC_PROT] && walk_reads == 4'd0);

    // R9
    rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err[EC_RSVD] |-> rsp_fault && rsp_err[EC_PROT]);

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

    localparam int PA_W = 52;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            nx_enable = 1'b0;
    logic [PA_W-1:0] root_base = 52'h1000;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [63:0]     req_va = '0;
    logic            req_write = 1'b0;
    logic            req_user = 1'b0;
    logic            req_fetch = 1'b0;
    logic            mem_req_valid;
    logic            mem_req_ready;
    logic [PA_W-1:0] mem_req_addr;
    logic            mem_rsp_valid = 1'b0;
    logic            mem_rsp_ready;
    logic [63:0]     mem_rsp_data = '0;
    logic            rsp_valid;
    logic            rsp_ready = 1'b0;
    logic            rsp_fault;
    logic            rsp_canon_fault;
    logic [4:0]      rsp_err;
    logic [PA_W-1:0] rsp_pa;
    logic [1:0]      rsp_page_size;
    logic            rsp_writable;
    logic            rsp_user;
    logic            rsp_nx;

    always #4 clk = ~clk;

    pt_walker #(.PA_W(PA_W)) dut (
        .clk(clk), .rst_n(rst_n), .nx_enable(nx_enable), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_canon_fault(rsp_canon_fault), .rsp_err(rsp_err), .rsp_pa(rsp_pa),
        .rsp_page_size(rsp_page_size), .rsp_writable(rsp_writable), .rsp_user(rsp_user),
        .rsp_nx(rsp_nx)
    );

    // memory model: plain array, one-cycle response
    logic [63:0] mem [0:4095];
    int          reads = 0;
    int          cyc = 0;
    logic        stall = 1'b0;

    assign mem_req_ready = !stall || cyc[0];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[mem_req_addr[14:3]];
            reads         <= reads + 1;
        end else if (mem_rsp_valid && mem_rsp_ready) begin
            mem_rsp_valid <= 1'b0;
        end
    end

    int total = 0;
    int fails = 0;

    logic            r_fault, r_canon, r_w, r_u, r_nx;
    logic [4:0]      r_err;
    logic [PA_W-1:0] r_pa;
    logic [1:0]      r_size;
    int              r_reads;

    function automatic logic [63:0] mkva(input logic [8:0] a, input logic [8:0] b,
                                         input logic [8:0] c, input logic [8:0] d,
                                         input logic [11:0] o);
        logic [47:0] v;
        v = {a, b, c, d, o};
        return {{16{v[47]}}, v};
    endfunction

    task automatic put(input int base, input int idx, input logic [63:0] val);
        mem[(base >> 3) + idx] = val;
    endtask

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic run_walk(input logic [63:0] va, input logic w, input logic u,
                            input logic f, input logic nxe, input int hold);
        int r0;
        @(negedge clk);
        req_va = va; req_write = w; req_user = u; req_fetch = f; nx_enable = nxe;
        r0 = reads;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        r_fault = rsp_fault; r_canon = rsp_canon_fault; r_err = rsp_err; r_pa = rsp_pa;
        r_size = rsp_page_size; r_w = rsp_writable; r_u = rsp_user; r_nx = rsp_nx;
        r_reads = reads - r0;
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk("R10 result held valid", 64'(rsp_valid), 64'd1);
            chk("R10 result pa stable", 64'(rsp_pa), 64'(r_pa));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 req_ready after reset", 64'(req_ready), 64'd1);
        chk("R11 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        chk("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_4k();
        logic [63:0] va;
        va = mkva(9'd1, 9'd2, 9'd3, 9'd4, 12'h567);
        run_walk(va, 1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk("R2 4k no fault", 64'(r_fault), 64'd0);
        chk("R2 4k pa", 64'(r_pa), 64'hABCD_E567);
        chk("R2 4k reads", 64'(r_reads), 64'd4);
        chk("R12 4k size", 64'(r_size), 64'd0);
        chk("R12 4k writable", 64'(r_w), 64'd1);
        chk("R12 4k user", 64'(r_u), 64'd1);
        chk("R8 success code zero", 64'(r_err), 64'd0);
        run_walk(va, 1'b1, 1'b1, 1'b0, 1'b1, 0);
        chk("R6 user write allowed", 64'(r_fault), 64'd0);
    endtask

    task automatic t_2m();
        logic [63:0] va;
        va = mkva(9'd1, 9'd2, 9'd6, 9'h0D5, 12'hBCD);
        run_walk(va, 1'b1, 1'b1, 1'b0, 1'b1, 0);
        chk("R4 2m no fault", 64'(r_fault), 64'd0);
        chk("R4 2m pa", 64'(r_pa), 64'h1_2340_0000 | (va & 64'h1F_FFFF));
        chk("R4 2m reads", 64'(r_reads), 64'd3);
        chk("R12 2m size", 64'(r_size), 64'd1);
        va = mkva(9'd1, 9'd2, 9'd14, 9'h011, 12'h222);
        run_walk(va, 1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk("R4 bit12 not frame, no fault", 64'(r_fault), 64'd0);
        chk("R4 bit12 not frame, pa", 64'(r_pa), 64'h40_0000 | (va & 64'h1F_FFFF));
    endtask

    task automatic t_1g();
        logic [63:0] va;
        va = mkva(9'd1, 9'd7, 9'h091, 9'h1A2, 12'h678);
        run_walk(va, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        chk("R3 1g no fault", 64'(r_fault), 64'd0);
        chk("R3 1g pa", 64'(r_pa), 64'hC000_0000 | (va & 64'h3FFF_FFFF));
        chk("R3 1g reads", 64'(r_reads), 64'd2);
        chk("R12 1g size", 64'(r_size), 64'd2);
        chk("R12 1g not writable", 64'(r_w), 64'd0);
        run_walk(va, 1'b1, 1'b0, 1'b0, 1'b1, 0);
        chk("R6 write to read-only 1g faults", 64'(r_fault), 64'd1);
        chk("R6 write to read-only 1g code", 64'(r_err), 64'h3);
    endtask

    task automatic t_rights();
        logic [63:0] va;
        va = mkva(9'd12, 9'd0, 9'd1, 9'd2, 12'h003);
        run_walk(va, 1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk("R6 upper level read-only: read ok", 64'(r_fault), 64'd0);
        chk("R6 upper level read-only: merged writable", 64'(r_w), 64'd0);
        chk("R6 upper level read-only: pa", 64'(r_pa), 64'h4000_0000 | (va & 64'h3FFF_FFFF));
        run_walk(va, 1'b1, 1'b0, 1'b0, 1'b1, 0);
        chk("R6 upper level read-only: write code", 64'(r_err), 64'h3);
        va = mkva(9'd1, 9'd2, 9'd3, 9'd5, 12'h0F0);
        run_walk(va, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        chk("R6 user read of supervisor page faults", 64'(r_fault), 64'd1);
        chk("R6 user read of supervisor page code", 64'(r_err), 64'h5);
    endtask

    task automatic t_nx();
        logic [63:0] va;
        va = mkva(9'd1, 9'd2, 9'd3, 9'd5, 12'h0F0);
        run_walk(va, 1'b0, 1'b0, 1'b1, 1'b1, 0);
        chk("R7 fetch from nx page, enforced", 64'(r_fault), 64'd1);
        chk("R7 fetch fault code", 64'(r_err), 64'h11);
        run_walk(va, 1'b0, 1'b0, 1'b1, 1'b0, 0);
        chk("R7 fetch with enforcement off", 64'(r_fault), 64'd0);
        chk("R7 merged nx reported", 64'(r_nx), 64'd1);
        chk("R7 pa", 64'(r_pa), 64'h5555_50F0);
        run_walk(va, 1'b1, 1'b0, 1'b0, 1'b1, 0);
        chk("R7 data write to nx page ok", 64'(r_fault), 64'd0);
    endtask

    task automatic t_not_present();
        run_walk(mkva(9'd1, 9'd2, 9'd8, 9'd0, 12'h0), 1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk("R5 third-level missing faults", 64'(r_fault), 64'd1);
        chk("R5 third-level missing code", 64'(r_err), 64'h0);
        chk("R5 third-level missing reads", 64'(r_reads), 64'd3);
        run_walk(mkva(9'd9, 9'd0, 9'd0, 9'd0, 12'h0), 1'b1, 1'b1, 1'b0, 1'b1, 0);
        chk("R5 top-level missing reads", 64'(r_reads), 64'd1);
        chk("R8 missing entry code with write+user", 64'(r_err), 64'h6);
    endtask

    task automatic t_reserved();
        run_walk(mkva(9'd1, 9'd10, 9'd0, 9'd0, 12'h0), 1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk("R9 misaligned 1g code", 64'(r_err), 64'h9);
        chk("R9 misaligned 1g reads", 64'(r_reads), 64'd2);
        run_walk(mkva(9'd11, 9'd0, 9'd0, 9'd0, 12'h0), 1'b0, 1'b0, 1'b1, 1'b1, 0);
        chk("R9 top-level huge bit code with fetch R8", 64'(r_err), 64'h19);
        chk("R9 top-level huge bit reads", 64'(r_reads), 64'd1);
        run_walk(mkva(9'd1, 9'd2, 9'd13, 9'd0, 12'h0), 1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk("R9 misaligned 2m code", 64'(r_err), 64'h9);
        chk("R9 misaligned 2m reads", 64'(r_reads), 64'd3);
    endtask

    task automatic t_canon();
        run_walk(64'h0000_8000_0000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 0);
        chk("R1 just above low half faults", 64'(r_canon), 64'd1);
        chk("R1 non-canonical code R8", 64'(r_err), 64'h6);
        chk("R1 non-canonical reads", 64'(r_reads), 64'd0);
        run_walk(64'hFFFF_7FFF_FFFF_F000, 1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk("R1 just below high half faults", 64'(r_canon), 64'd1);
        run_walk(64'hFFFF_8000_0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk("R1 high half accepted", 64'(r_canon), 64'd0);
        chk("R1 high half walked one read", 64'(r_reads), 64'd1);
        chk("R5 high half missing root entry", 64'(r_fault), 64'd1);
        run_walk(64'h0000_7FFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk("R1 top of low half accepted", 64'(r_canon), 64'd0);
    endtask

    task automatic t_backpressure();
        stall = 1'b1;
        run_walk(mkva(9'd1, 9'd2, 9'd3, 9'd4, 12'h001), 1'b0, 1'b0, 1'b0, 1'b1, 3);
        stall = 1'b0;
        chk("R10 stalled walk pa", 64'(r_pa), 64'hABCD_E001);
        chk("R10 stalled walk reads", 64'(r_reads), 64'd4);
        chk("R10 idle after result", 64'(req_ready), 64'd1);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_4k();
        t_2m();
        t_1g();
        t_rights();
        t_nx();
        t_not_present();
        t_reserved();
        t_canon();
        t_backpressure();
    endtask

    initial begin
        logic wd;
        wd = 1'b0;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        // top level at 0x1000
        put(32'h1000, 1,   64'h0000_0000_0000_2007);
        put(32'h1000, 11,  64'h0000_0000_0000_2087);
        put(32'h1000, 12,  64'h0000_0000_0000_5005);
        // second level at 0x2000
        put(32'h2000, 2,   64'h0000_0000_0000_3007);
        put(32'h2000, 7,   64'h0000_0000_C000_0085);
        put(32'h2000, 10,  64'h0000_0000_C000_2083);
        // third level at 0x3000
        put(32'h3000, 3,   64'h0000_0000_0000_4007);
        put(32'h3000, 6,   64'h0000_0001_2340_0087);
        put(32'h3000, 13,  64'h0000_0000_0020_2083);
        put(32'h3000, 14,  64'h0000_0000_0040_1083);
        // last level at 0x4000
        put(32'h4000, 4,   64'h0000_0000_ABCD_E007);
        put(32'h4000, 5,   64'h8000_0000_5555_5003);
        // second level at 0x5000
        put(32'h5000, 0,   64'h0000_0000_4000_0087);

        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule